// File: doc/BRIEF.md
# Card access strobe timing sequencer

This block produces the card-side control waveform for one access to a removable card. A single-cycle start request launches the sequence. The block latches the access direction, the space type (I/O or memory/attribute) and three cycle counts taken from a window option word. It then drives chip-enable through three back-to-back phases. The first is an address setup phase, the second is a strobe phase in which the read or write strobe for the chosen space is active, and the last is a hold phase.

For reads, a capture pulse marks the cycle in which the host should sample card data. A done pulse reports normal completion. A bus-monitor watchdog caps every access. When the access runs too long, the watchdog takes all card controls low and raises an error pulse in place of done. Address decoding and the host bus protocol sit outside this block.

Top module: `card_strobe_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, every output is 0, including busy.
- R2: The setup count is taken from option bits 15:12, the strobe count from bits 11:7 and the hold count from bits 19:16, all in clock cycles. Option bits outside these three fields have no effect.
- R3: A start seen on a clock edge while idle begins the access in the next cycle. The phases run setup, then strobe, then hold, and chip-enable is high in every one of those cycles.
- R4: A strobe is high only in strobe-phase cycles. With io_i=1 the block uses io_rd_o (wr_i=0) or io_wr_o (wr_i=1). With io_i=0 it uses mem_oe_o (wr_i=0) or mem_we_o (wr_i=1). At most one strobe is high at a time.
- R5: A setup or hold count of zero removes that phase. A strobe count of zero still gives one strobe cycle.
- R6: A read gives exactly one capture pulse, in the last strobe cycle. A write gives none.
- R7: If setup + strobe + hold (strobe counted as at least 1) is below 60, done is high for exactly one cycle, the cycle right after the last active cycle, and all card controls are low in that cycle.
- R8: If that total is 60 or more, cycle 60 after start (counting the first active cycle as 0) has all card controls low, err_o high for one cycle and no done. A done pulse never appears for such an access.
- R9: busy_o is high from the first active cycle through the done or error cycle and low again in the following cycle. A start that arrives while busy is ignored.
- R10: wr_i, io_i and opt_i are sampled only when a start is accepted. Changing them during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, one cycle |
| wr_i | input | 1 | 1 = write access, 0 = read |
| io_i | input | 1 | 1 = I/O space, 0 = memory or attribute space |
| opt_i | input | OPT_W (32) | Window option word carrying the three cycle counts |
| ce_o | output | 1 | Card chip-enable |
| mem_oe_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| capture_o | output | 1 | Read-data capture pulse |
| done_o | output | 1 | Normal completion pulse |
| err_o | output | 1 | Bus-monitor timeout pulse |
| busy_o | output | 1 | Access in progress |

## Verification
Short accesses are run in all four direction/space combinations. These runs separate the four strobe pins and show that capture follows reads only. Count patterns with zero setup, zero hold or zero strobe show that phases are skipped and that the strobe has a one-cycle floor. Totals of 59, 60 and 61 cycles separate a late done from a watchdog abort. Further runs add option words with junk outside the fields, inputs changed after start, and start pulses during an access and during the done cycle. These show that only the latched fields at the accepted start matter.

// File: rtl/cstrb_pkg.sv
package cstrb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_FIN,
        PH_ABORT
    } phase_e;

    typedef struct packed {
        logic is_write;
        logic is_io;
    } acc_kind_t;

    typedef struct packed {
        logic ce;
        logic mem_oe;
        logic mem_we;
        logic io_rd;
        logic io_wr;
        logic capture;
        logic done;
        logic err;
        logic busy;
    } pins_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic phase_active(input phase_e p);
        return (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_HOLD);
    endfunction

endpackage

// File: rtl/cstrb_cfg_latch.sv
module cstrb_cfg_latch
    import cstrb_pkg::*;
#(
    parameter int OPT_W      = 32,
    parameter int SETUP_LSB  = 12,
    parameter int SETUP_W    = 4,
    parameter int STROBE_LSB = 7,
    parameter int STROBE_W   = 5,
    parameter int HOLD_LSB   = 16,
    parameter int HOLD_W     = 4,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             wr_i,
    input  logic             io_i,
    input  logic [OPT_W-1:0] opt_i,
    output logic [CNT_W-1:0] live_setup_o,
    output logic [CNT_W-1:0] live_strobe_o,
    output logic [CNT_W-1:0] held_strobe_o,
    output logic [CNT_W-1:0] held_hold_o,
    output acc_kind_t        kind_o
);
    logic [CNT_W-1:0] raw_setup, raw_strobe, raw_hold;
    logic             opt_unused;

    assign raw_setup  = CNT_W'(opt_i[SETUP_LSB  +: SETUP_W]);
    assign raw_strobe = CNT_W'(opt_i[STROBE_LSB +: STROBE_W]);
    assign raw_hold   = CNT_W'(opt_i[HOLD_LSB   +: HOLD_W]);
    assign opt_unused = ^opt_i;

    // strobe phase has a one-cycle floor
    assign live_setup_o  = raw_setup;
    assign live_strobe_o = (raw_strobe == '0) ? CNT_W'(1) : raw_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_strobe_o <= CNT_W'(1);
            held_hold_o   <= '0;
            kind_o        <= '0;
        end else if (load) begin
            held_strobe_o   <= live_strobe_o;
            held_hold_o     <= raw_hold;
            kind_o.is_write <= wr_i;
            kind_o.is_io    <= io_i;
        end
    end

endmodule

// File: rtl/cstrb_phase_fsm.sv
module cstrb_phase_fsm
    import cstrb_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int BMT_LIMIT = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] live_setup_i,
    input  logic [CNT_W-1:0] live_strobe_i,
    input  logic [CNT_W-1:0] held_strobe_i,
    input  logic [CNT_W-1:0] held_hold_i,
    output logic             accept_o,
    output phase_e           phase_o,
    output logic             last_strobe_o
);
    localparam int               WD_W    = $clog2(BMT_LIMIT + 1);
    localparam logic [WD_W-1:0]  WD_LAST = WD_W'(BMT_LIMIT - 1);

    phase_e           phase, phase_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [WD_W-1:0]  wd;

    assign accept_o      = (phase == PH_IDLE) && start_i;
    assign phase_o       = phase;
    assign last_strobe_o = (phase == PH_STROBE) && (cnt == '0);

    always_comb begin
        phase_n = phase;
        cnt_n   = cnt;
        unique case (phase)
            PH_IDLE: begin
                if (start_i) begin
                    if (live_setup_i != '0) begin
                        phase_n = PH_SETUP;
                        cnt_n   = live_setup_i - CNT_W'(1);
                    end else begin
                        phase_n = PH_STROBE;
                        cnt_n   = live_strobe_i - CNT_W'(1);
                    end
                end
            end
            PH_SETUP: begin
                if (cnt == '0) begin
                    phase_n = PH_STROBE;
                    cnt_n   = held_strobe_i - CNT_W'(1);
                end else begin
                    cnt_n = cnt - CNT_W'(1);
                end
            end
            PH_STROBE: begin
                if (cnt == '0) begin
                    if (held_hold_i != '0) begin
                        phase_n = PH_HOLD;
                        cnt_n   = held_hold_i - CNT_W'(1);
                    end else begin
                        phase_n = PH_FIN;
                    end
                end else begin
                    cnt_n = cnt - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (cnt == '0) phase_n = PH_FIN;
                else           cnt_n   = cnt - CNT_W'(1);
            end
            PH_FIN, PH_ABORT: phase_n = PH_IDLE;
            default:          phase_n = PH_IDLE;
        endcase
        // bus monitor overrides whatever comes next
        if (phase_active(phase) && (wd == WD_LAST)) begin
            phase_n = PH_ABORT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            wd    <= '0;
        end else begin
            phase <= phase_n;
            cnt   <= cnt_n;
            if (accept_o)                wd <= '0;
            else if (phase_active(phase)) wd <= wd + WD_W'(1);
        end
    end

    // R8: no active cycle at or beyond the bus-monitor limit
    a_r8_wd_bound: assert property (@(posedge clk) disable iff (rst)
        phase_active(phase) |-> (wd < WD_W'(BMT_LIMIT)));

    // R3: hold is only entered from strobe
    a_r3_hold_after_strobe: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && $past(phase) != PH_HOLD) |-> ($past(phase) == PH_STROBE));

    // R3: strobe is only entered from setup or idle
    a_r3_strobe_entry: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE && $past(phase) != PH_STROBE)
            |-> ($past(phase) == PH_SETUP || $past(phase) == PH_IDLE));

    // R9: an access leaves idle only on a start
    a_r9_leave_idle: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !start_i) |=> (phase == PH_IDLE));

endmodule

// File: rtl/cstrb_pin_decode.sv
module cstrb_pin_decode
    import cstrb_pkg::*;
(
    input  phase_e    phase_i,
    input  logic      last_strobe_i,
    input  acc_kind_t kind_i,
    output pins_t     pins_o
);
    logic in_strobe;

    assign in_strobe = (phase_i == PH_STROBE);

    always_comb begin
        pins_o         = '0;
        pins_o.ce      = phase_active(phase_i);
        pins_o.mem_oe  = in_strobe && !kind_i.is_io && !kind_i.is_write;
        pins_o.mem_we  = in_strobe && !kind_i.is_io &&  kind_i.is_write;
        pins_o.io_rd   = in_strobe &&  kind_i.is_io && !kind_i.is_write;
        pins_o.io_wr   = in_strobe &&  kind_i.is_io &&  kind_i.is_write;
        pins_o.capture = last_strobe_i && !kind_i.is_write;
        pins_o.done    = (phase_i == PH_FIN);
        pins_o.err     = (phase_i == PH_ABORT);
        pins_o.busy    = (phase_i != PH_IDLE);
    end

endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq
    import cstrb_pkg::*;
#(
    parameter int OPT_W      = 32,
    parameter int SETUP_LSB  = 12,
    parameter int SETUP_W    = 4,
    parameter int STROBE_LSB = 7,
    parameter int STROBE_W   = 5,
    parameter int HOLD_LSB   = 16,
    parameter int HOLD_W     = 4,
    parameter int BMT_LIMIT  = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             wr_i,
    input  logic             io_i,
    input  logic [OPT_W-1:0] opt_i,
    output logic             ce_o,
    output logic             mem_oe_o,
    output logic             mem_we_o,
    output logic             io_rd_o,
    output logic             io_wr_o,
    output logic             capture_o,
    output logic             done_o,
    output logic             err_o,
    output logic             busy_o
);
    localparam int CNT_W = max3(SETUP_W, STROBE_W, HOLD_W);

    logic [CNT_W-1:0] live_setup, live_strobe, held_strobe, held_hold;
    logic             accept, last_strobe;
    acc_kind_t        kind;
    phase_e           phase;
    pins_t            pins;

    cstrb_cfg_latch #(
        .OPT_W(OPT_W), .SETUP_LSB(SETUP_LSB), .SETUP_W(SETUP_W),
        .STROBE_LSB(STROBE_LSB), .STROBE_W(STROBE_W),
        .HOLD_LSB(HOLD_LSB), .HOLD_W(HOLD_W), .CNT_W(CNT_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .load(accept), .wr_i(wr_i), .io_i(io_i),
        .opt_i(opt_i), .live_setup_o(live_setup), .live_strobe_o(live_strobe),
        .held_strobe_o(held_strobe), .held_hold_o(held_hold), .kind_o(kind)
    );

    cstrb_phase_fsm #(.CNT_W(CNT_W), .BMT_LIMIT(BMT_LIMIT)) u_fsm (
        .clk(clk), .rst(rst), .start_i(start_i),
        .live_setup_i(live_setup), .live_strobe_i(live_strobe),
        .held_strobe_i(held_strobe), .held_hold_i(held_hold),
        .accept_o(accept), .phase_o(phase), .last_strobe_o(last_strobe)
    );

    cstrb_pin_decode u_dec (
        .phase_i(phase), .last_strobe_i(last_strobe), .kind_i(kind), .pins_o(pins)
    );

    assign ce_o      = pins.ce;
    assign mem_oe_o  = pins.mem_oe;
    assign mem_we_o  = pins.mem_we;
    assign io_rd_o   = pins.io_rd;
    assign io_wr_o   = pins.io_wr;
    assign capture_o = pins.capture;
    assign done_o    = pins.done;
    assign err_o     = pins.err;
    assign busy_o    = pins.busy;

    // R4: never more than one strobe, and only under chip-enable
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_oe_o, mem_we_o, io_rd_o, io_wr_o}));
    a_r4_strobe_under_ce: assert property (@(posedge clk) disable iff (rst)
        (mem_oe_o || mem_we_o || io_rd_o || io_wr_o) |-> ce_o);

    // R6: capture only alongside a read strobe
    a_r6_capture_on_read: assert property (@(posedge clk) disable iff (rst)
        capture_o |-> (mem_oe_o || io_rd_o));

    // R7 / R8: done and error never together, both follow an active cycle
    a_r7_done_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));
    a_r7_done_after_ce: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(ce_o) && !ce_o));
    a_r8_err_drops_ce: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!ce_o && $past(ce_o)));

    // R3: chip-enable rises only the cycle after a start
    a_r3_ce_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_o) |-> $past(start_i));

    // R9: busy covers the whole access
    a_r9_busy_cover: assert property (@(posedge clk) disable iff (rst)
        (ce_o || done_o || err_o) |-> busy_o);

endmodule

// File: tb/card_strobe_seq_test.sv
module card_strobe_seq_test;
    localparam int CLK_P    = 10;
    localparam int WD_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        wr_i = 1'b0;
    logic        io_i = 1'b0;
    logic [31:0] opt_i = '0;
    logic ce_o, mem_oe_o, mem_we_o, io_rd_o, io_wr_o, capture_o, done_o, err_o, busy_o;

    typedef logic [8:0] vec_t; // ce oe we iord iowr cap done err busy

    vec_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;

    card_strobe_seq uut (
        .clk(clk), .rst(rst), .start_i(start_i), .wr_i(wr_i), .io_i(io_i),
        .opt_i(opt_i), .ce_o(ce_o), .mem_oe_o(mem_oe_o), .mem_we_o(mem_we_o),
        .io_rd_o(io_rd_o), .io_wr_o(io_wr_o), .capture_o(capture_o),
        .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic vec_t actual();
        return {ce_o, mem_oe_o, mem_we_o, io_rd_o, io_wr_o, capture_o, done_o, err_o, busy_o};
    endfunction

    task automatic check_now(input vec_t e, input string t);
        checks++;
        if (actual() !== e) begin
            fails++;
            $display("FAIL %s: got %b expected %b", t, actual(), e);
        end
    endtask

    // monitor: one expected item per cycle, sampled a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                vec_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_now(e, t);
            end
        end
    end

    task automatic push(input vec_t v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // driver: launches one access, queues its expected waveform, optionally pokes start
    task automatic run_access(input int s, input int l, input int h, input bit w, input bit i,
                              input logic [31:0] junk, input int poke, input bit scramble,
                              input string tag);
        int   lm, n, last;
        vec_t strb;
        lm = (l == 0) ? 1 : l;
        n  = s + lm + h;
        opt_i = junk;
        opt_i[15:12] = s[3:0];
        opt_i[11:7]  = l[4:0];
        opt_i[19:16] = h[3:0];
        wr_i = w;
        io_i = i;
        start_i = 1'b1;
        strb = {1'b1, !i && !w, !i && w, i && !w, i && w, 1'b0, 1'b0, 1'b0, 1'b1};
        last = (n < 60) ? n - 1 : 59;
        for (int k = 0; k <= last; k++) begin
            if (k < s)
                push(9'b1_0000_0001, $sformatf("R3 R5 %s setup k=%0d", tag, k));
            else if (k < s + lm) begin
                vec_t v;
                v = strb;
                if (!w && k == s + lm - 1) v[3] = 1'b1;
                push(v, $sformatf("R4 R6 %s strobe k=%0d", tag, k));
            end else
                push(9'b1_0000_0001, $sformatf("R3 R5 %s hold k=%0d", tag, k));
        end
        if (n < 60) push(9'b0_0000_0101, $sformatf("R7 %s done k=%0d", tag, n));
        else        push(9'b0_0000_0011, $sformatf("R8 %s abort k=60", tag));
        push(9'b0, $sformatf("R9 %s idle after", tag));
        @(negedge clk);
        start_i = 1'b0;
        if (scramble) begin
            wr_i  = !w;
            io_i  = !i;
            opt_i = ~opt_i;
        end
        for (int j = 0; exp_q.size() > 0; j++) begin
            start_i = (j == poke);
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        while (cycles < WD_LIMIT) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_now(9'b0, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check_now(9'b0, "R1 after reset");

        run_access(2, 3, 1, 1'b0, 1'b0, 32'h0, -1, 1'b0, "R4 mem read");
        run_access(2, 3, 1, 1'b1, 1'b0, 32'h0, -1, 1'b0, "R4 mem write");
        run_access(1, 2, 2, 1'b0, 1'b1, 32'h0, -1, 1'b0, "R4 io read");
        run_access(1, 2, 2, 1'b1, 1'b1, 32'h0, -1, 1'b0, "R4 io write");
        run_access(0, 0, 0, 1'b0, 1'b0, 32'h0, -1, 1'b0, "R5 all zero");
        run_access(0, 4, 3, 1'b0, 1'b1, 32'h0, -1, 1'b0, "R5 no setup");
        run_access(3, 1, 0, 1'b1, 1'b0, 32'h0, -1, 1'b0, "R5 no hold");
        run_access(2, 2, 2, 1'b0, 1'b0, 32'hFFF0_007F, -1, 1'b0, "R2 junk bits");
        run_access(5, 9, 6, 1'b1, 1'b1, 32'h0, -1, 1'b0, "R2 wide fields");
        run_access(2, 3, 2, 1'b0, 1'b1, 32'h0, 2, 1'b0, "R9 start mid access");
        run_access(1, 1, 1, 1'b1, 1'b0, 32'h0, 3, 1'b0, "R9 start in done cycle");
        run_access(2, 3, 2, 1'b0, 1'b0, 32'h0, -1, 1'b1, "R10 inputs changed");
        run_access(15, 29, 15, 1'b0, 1'b0, 32'h0, -1, 1'b0, "R7 total 59");
        run_access(15, 30, 15, 1'b0, 1'b1, 32'h0, -1, 1'b0, "R8 total 60");
        run_access(15, 31, 15, 1'b1, 1'b0, 32'h0, 10, 1'b0, "R8 total 61");
        run_access(0, 1, 0, 1'b1, 1'b1, 32'h0, -1, 1'b0, "R3 back to back");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule